// File: doc/BRIEF.md
# ATA Task-File Command Controller

This block is the device end of an ATA-style task-file register set that sits behind a small host I/O port with 16-bit data and 8-bit registers. The host writes the sector count, three LBA bytes and the device/head byte, then writes a command code. The block answers by reporting a status byte and running one of four commands:

- **Identify** streams a 256-word descriptor through the data port. The stream is paced by DRQ.
- **Flush cache** holds BSY until an external completion pulse arrives.
- **Read DMA / write DMA** raise a transfer request toward a separate DMA engine and hold BSY until that engine reports done.

A single interrupt line flags command results, and a host read of the status register clears it.

The controller has four named states:

- `ST_IDLE` (ready)
- `ST_IDENT` (identify words pending)
- `ST_FLUSH` (flush in flight)
- `ST_DMA` (DMA transfer in flight)

Its transitions are:

- `IDLE→IDENT` on command 0xEC.
- `IDLE→FLUSH` on command 0xE7.
- `IDLE→DMA` on commands 0xC8 or 0xCA.
- `IDENT→IDLE` on the data read of the last word.
- `FLUSH→IDLE` on `flush_done`.
- `DMA→IDLE` on `dma_done`.
- `IDLE→IDLE` with ERR on any other code.

Top module: `tfc_top`

## Requirements
- R1: Register offsets on `bus_addr` are 0 data, 2 sector count, 3 LBA bits 7:0, 4 LBA bits 15:8, 5 LBA bits 23:16, 6 device/head, and 7 status on read or command on write. Writes to offsets 2 to 6 store the low byte, and reads return it with bits 15:8 zero. The device/head byte reads back exactly as written, so writing 0x40 (LBA mode, device 0 in bit 4) reads back with bit 4 clear.
- R2: Status bits are BSY bit 7, DRDY bit 6, DF bit 5, DRQ bit 3 and ERR bit 0. After reset, status reads 0x40 and `irq` is low.
- R3: Command 0xEC raises `irq`. It sets status to 0x48 (DRDY and DRQ) for each of 256 data-port reads. After the 256th read, status returns to 0x40.
- R4: Identify word n, for n from 0, is built as follows. Words 10 to 19 hold the 20-character `SERIAL_STR` (default "TFC-UNIT-0000000042 ") two characters per word, with the first character in bits 15:8. Words 23 to 26 hold the 8-character `VERSION_STR` (default "REV-1.0 ") in the same way. Word 85 is 0x0020, which reports the write cache as enabled. Every other word is 0.
- R5: Command 0xE7 sets status to 0xC0 (BSY and DRDY) until `flush_done` pulses. Status then becomes 0x40 and `irq` rises.
- R6: Command 0xC8 or 0xCA asserts `dma_req` with status 0xC0. `dma_to_mem` is 1 for 0xC8 and 0 for 0xCA. On `dma_done`, `dma_req` drops, status becomes 0x40 and `irq` rises.
- R7: A read at offset 7 clears `irq` after that cycle. If a completion event lands in the same cycle as the status read, the event wins and `irq` stays high.
- R8: A command write while BSY or DRQ is set is ignored: state, status and outputs are unchanged.
- R9: Any other command code leaves BSY clear, sets ERR (status 0x41) and raises `irq`. The next accepted command clears ERR.
- R10: `flush_done` and `dma_done` are ignored outside the command that waits for them.
- R11: `xfer_count` and `xfer_lba` always show the stored sector count and the 24-bit LBA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data (low byte for registers) |
| bus_rdata | output | 16 | Read data for the current offset |
| flush_done | input | 1 | Completion pulse for a pending flush |
| dma_done | input | 1 | Completion pulse from the DMA engine |
| dma_req | output | 1 | Transfer request to the DMA engine |
| dma_to_mem | output | 1 | 1 = device to memory (read), 0 = memory to device |
| xfer_count | output | 8 | Stored sector count |
| xfer_lba | output | 24 | Stored LBA |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that `bus_rd` and `bus_wr` are never high in the same cycle, and that each strobe lasts one cycle per access. They also assume completion pulses are single-cycle. The stimulus drives every strobe for exactly one clock from the falling edge and never overlaps a read with a write. It also issues completion pulses only while the matching command is in flight, apart from the deliberate stray pulses used for R10.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_IDENT = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DMA   = 2'd3
    } tfc_state_t;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_COUNT = 3'd2;
    localparam logic [2:0] OFS_LBA0  = 3'd3;
    localparam logic [2:0] OFS_LBA1  = 3'd4;
    localparam logic [2:0] OFS_LBA2  = 3'd5;
    localparam logic [2:0] OFS_DEVHD = 3'd6;
    localparam logic [2:0] OFS_STCMD = 3'd7;

    localparam logic [7:0] OP_IDENT = 8'hEC;
    localparam logic [7:0] OP_FLUSH = 8'hE7;
    localparam logic [7:0] OP_RDDMA = 8'hC8;
    localparam logic [7:0] OP_WRDMA = 8'hCA;
endpackage

// File: rtl/tfc_regs.sv
module tfc_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_ofs,
    input  logic [7:0]  wr_byte,
    output logic [7:0]  count_q,
    output logic [23:0] lba_q,
    output logic [7:0]  devhd_q
);
    import tfc_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            lba_q   <= '0;
            devhd_q <= '0;
        end else if (wr_en) begin
            unique case (wr_ofs)
                OFS_COUNT: count_q       <= wr_byte;
                OFS_LBA0:  lba_q[7:0]    <= wr_byte;
                OFS_LBA1:  lba_q[15:8]   <= wr_byte;
                OFS_LBA2:  lba_q[23:16]  <= wr_byte;
                OFS_DEVHD: devhd_q       <= wr_byte;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tfc_ident_rom.sv
module tfc_ident_rom #(
    parameter int          IDX_W       = 8,
    parameter logic [159:0] SERIAL_STR = "TFC-UNIT-0000000042 ",
    parameter logic [63:0]  VERSION_STR = "REV-1.0 "
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      word
);
    localparam int SER_FIRST = 10;
    localparam int SER_WORDS = 10;
    localparam int VER_FIRST = 23;
    localparam int VER_WORDS = 4;
    localparam int CACHE_WRD = 85;

    always_comb begin
        int n;
        n = int'(idx);
        word = 16'h0000;
        if (n >= SER_FIRST && n < SER_FIRST + SER_WORDS)
            word = SERIAL_STR[159 - 16*(n - SER_FIRST) -: 16];
        else if (n >= VER_FIRST && n < VER_FIRST + VER_WORDS)
            word = VERSION_STR[63 - 16*(n - VER_FIRST) -: 16];
        else if (n == CACHE_WRD)
            word = 16'h0020;
    end
endmodule

// File: rtl/tfc_fsm.sv
module tfc_fsm #(
    parameter int IDENT_WORDS = 256,
    localparam int IDX_W = $clog2(IDENT_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_code,
    input  logic             data_rd,
    input  logic             stat_rd,
    input  logic             flush_done,
    input  logic             dma_done,
    output logic             bsy,
    output logic             drq,
    output logic             err,
    output logic             irq,
    output logic             dma_req,
    output logic             dma_to_mem,
    output logic [IDX_W-1:0] word_idx
);
    import tfc_pkg::*;

    tfc_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             err_q, err_d, irq_q, irq_set, dir_q, dir_d;
    logic             accept;

    assign accept = cmd_we && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        err_d   = err_q;
        dir_d   = dir_q;
        irq_set = 1'b0;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                err_d = 1'b0;
                unique case (cmd_code)
                    OP_IDENT: begin state_d = ST_IDENT; idx_d = '0; irq_set = 1'b1; end
                    OP_FLUSH: state_d = ST_FLUSH;
                    OP_RDDMA: begin state_d = ST_DMA; dir_d = 1'b1; end
                    OP_WRDMA: begin state_d = ST_DMA; dir_d = 1'b0; end
                    default:  begin err_d = 1'b1; irq_set = 1'b1; end
                endcase
            end
            ST_IDENT: if (data_rd) begin
                if (idx_q == IDX_W'(IDENT_WORDS - 1)) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_FLUSH: if (flush_done) begin state_d = ST_IDLE; irq_set = 1'b1; end
            ST_DMA:   if (dma_done)   begin state_d = ST_IDLE; irq_set = 1'b1; end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            err_q   <= 1'b0;
            dir_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            err_q   <= err_d;
            dir_q   <= dir_d;
            irq_q   <= irq_set ? 1'b1 : (stat_rd ? 1'b0 : irq_q);
        end
    end

    always_comb begin
        bsy        = (state_q == ST_FLUSH) || (state_q == ST_DMA);
        drq        = (state_q == ST_IDENT);
        err        = err_q;
        irq        = irq_q;
        dma_req    = (state_q == ST_DMA);
        dma_to_mem = dir_q;
        word_idx   = idx_q;
    end

    AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bsy && drq)); // R3
    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH && !flush_done) |=> bsy); // R5
    AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_done) |=> (dma_req && $stable(dma_to_mem))); // R6
    AST_DMA_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_done) |=> (!dma_req && irq)); // R6
    AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && state_q == ST_IDLE && !cmd_we) |=> !irq); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && bsy && !flush_done && !dma_done) |=> (bsy && $stable(err))); // R8
    AST_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && data_rd && idx_q == IDX_W'(IDENT_WORDS - 1)) |=> !drq); // R3
endmodule

// File: rtl/tfc_top.sv
module tfc_top #(
    parameter int           IDENT_WORDS = 256,
    parameter logic [159:0] SERIAL_STR  = "TFC-UNIT-0000000042 ",
    parameter logic [63:0]  VERSION_STR = "REV-1.0 "
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        flush_done,
    input  logic        dma_done,
    output logic        dma_req,
    output logic        dma_to_mem,
    output logic [7:0]  xfer_count,
    output logic [23:0] xfer_lba,
    output logic        irq
);
    import tfc_pkg::*;
    localparam int IDX_W = $clog2(IDENT_WORDS);

    logic [7:0]       count_q, devhd_q, status;
    logic [23:0]      lba_q;
    logic [IDX_W-1:0] word_idx;
    logic [15:0]      id_word;
    logic             bsy, drq, err;

    tfc_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_wr), .wr_ofs(bus_addr), .wr_byte(bus_wdata[7:0]),
        .count_q(count_q), .lba_q(lba_q), .devhd_q(devhd_q)
    );

    tfc_fsm #(.IDENT_WORDS(IDENT_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(bus_wr && bus_addr == OFS_STCMD),
        .cmd_code(bus_wdata[7:0]),
        .data_rd(bus_rd && bus_addr == OFS_DATA),
        .stat_rd(bus_rd && bus_addr == OFS_STCMD),
        .flush_done(flush_done), .dma_done(dma_done),
        .bsy(bsy), .drq(drq), .err(err), .irq(irq),
        .dma_req(dma_req), .dma_to_mem(dma_to_mem), .word_idx(word_idx)
    );

    tfc_ident_rom #(.IDX_W(IDX_W), .SERIAL_STR(SERIAL_STR), .VERSION_STR(VERSION_STR)) u_rom (
        .idx(word_idx), .word(id_word)
    );

    assign status     = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err};
    assign xfer_count = count_q;
    assign xfer_lba   = lba_q;

    always_comb begin
        unique case (bus_addr)
            OFS_DATA:  bus_rdata = drq ? id_word : 16'h0000;
            OFS_COUNT: bus_rdata = {8'h00, count_q};
            OFS_LBA0:  bus_rdata = {8'h00, lba_q[7:0]};
            OFS_LBA1:  bus_rdata = {8'h00, lba_q[15:8]};
            OFS_LBA2:  bus_rdata = {8'h00, lba_q[23:16]};
            OFS_DEVHD: bus_rdata = {8'h00, devhd_q};
            OFS_STCMD: bus_rdata = {8'h00, status};
            default:   bus_rdata = 16'h0000;
        endcase
    end

    AST_STATUS_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_STCMD) |-> (bus_rdata[6] && !bus_rdata[5])); // R2
    AST_XFER_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_COUNT) |=> (xfer_count == $past(bus_wdata[7:0]))); // R11
endmodule

// File: tb/sim_tfc_top.sv
module sim_tfc_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        flush_done = 1'b0, dma_done = 1'b0;
    logic        dma_req, dma_to_mem, irq;
    logic [7:0]  xfer_count;
    logic [23:0] xfer_lba;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    localparam logic [159:0] EXP_SER = "TFC-UNIT-0000000042 ";
    localparam logic [63:0]  EXP_VER = "REV-1.0 ";

    always #(CLK_PERIOD/2) clk = ~clk;

    tfc_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flush_done(flush_done),
        .dma_done(dma_done), .dma_req(dma_req), .dma_to_mem(dma_to_mem),
        .xfer_count(xfer_count), .xfer_lba(xfer_lba), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input bit is_flush);
        @(negedge clk);
        if (is_flush) flush_done = 1'b1; else dma_done = 1'b1;
        @(negedge clk);
        flush_done = 1'b0; dma_done = 1'b0;
    endtask

    function automatic logic [15:0] exp_word(input int n);
        if (n >= 10 && n <= 19) return EXP_SER[159 - 16*(n-10) -: 16];
        if (n >= 23 && n <= 26) return EXP_VER[63 - 16*(n-23) -: 16];
        if (n == 85) return 16'h0020;
        return 16'h0000;
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        check("R2 irq after reset", irq, 0);
        bus_read(3'd7, v);
        check("R2 status after reset", v, 16'h0040);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        bus_write(3'd2, 16'hAB05);
        bus_write(3'd3, 16'h0011);
        bus_write(3'd4, 16'h0022);
        bus_write(3'd5, 16'h0033);
        bus_write(3'd6, 16'h0040);
        bus_read(3'd2, v); check("R1 count readback", v, 16'h0005);
        bus_read(3'd3, v); check("R1 lba low", v, 16'h0011);
        bus_read(3'd5, v); check("R1 lba high", v, 16'h0033);
        bus_read(3'd6, v); check("R1 device bit4 clear", v, 16'h0040);
        check("R11 xfer_count", xfer_count, 8'h05);
        check("R11 xfer_lba", xfer_lba, 24'h332211);
    endtask

    task automatic t_identify();
        logic [15:0] v, s;
        bus_write(3'd7, 16'h00EC);
        check("R3 irq on identify", irq, 1);
        for (int i = 0; i < 256; i++) begin
            bus_read(3'd7, s);
            check("R3 status during stream", s, 16'h0048);
            bus_read(3'd0, v);
            check("R4 identify word", v, exp_word(i));
        end
        bus_read(3'd7, s);
        check("R3 status after last word", s, 16'h0040);
    endtask

    task automatic t_flush();
        logic [15:0] v;
        bus_write(3'd7, 16'h00E7);
        bus_read(3'd7, v); check("R5 flush pending", v, 16'h00C0);
        repeat (5) @(negedge clk);
        bus_read(3'd7, v); check("R5 still pending", v, 16'h00C0);
        pulse(1);
        check("R5 irq on flush done", irq, 1);
        bus_read(3'd7, v); check("R5 status after flush", v, 16'h0040);
        check("R7 status read clears irq", irq, 0);
    endtask

    task automatic t_dma(input logic [7:0] op, input bit to_mem);
        logic [15:0] v;
        bus_write(3'd7, {8'h00, op});
        check("R6 dma_req raised", dma_req, 1);
        check("R6 dma direction", dma_to_mem, to_mem);
        bus_read(3'd7, v); check("R6 dma busy status", v, 16'h00C0);
        pulse(0);
        check("R6 dma_req dropped", dma_req, 0);
        check("R6 irq on dma done", irq, 1);
        bus_read(3'd7, v); check("R6 status after dma", v, 16'h0040);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        bus_write(3'd7, 16'h00C8);
        bus_write(3'd7, 16'h00EC);
        bus_write(3'd7, 16'h0055);
        bus_read(3'd7, v); check("R8 command during BSY ignored", v, 16'h00C0);
        check("R8 dma_req kept", dma_req, 1);
        check("R8 direction kept", dma_to_mem, 1);
        @(negedge clk);
        dma_done = 1'b1; bus_addr = 3'd7; bus_rd = 1'b1;
        @(negedge clk);
        dma_done = 1'b0; bus_rd = 1'b0;
        check("R7 event beats same-cycle status read", irq, 1);
        bus_read(3'd7, v);
        check("R7 cleared after read", irq, 0);
        bus_write(3'd7, 16'h00EC);
        bus_write(3'd7, 16'h00E7);
        bus_read(3'd7, v); check("R8 command during DRQ ignored", v, 16'h0048);
        for (int i = 0; i < 256; i++) bus_read(3'd0, v);
    endtask

    task automatic t_unknown();
        logic [15:0] v;
        bus_read(3'd7, v);
        bus_write(3'd7, 16'h0012);
        check("R9 irq on unknown", irq, 1);
        bus_read(3'd7, v); check("R9 error status", v, 16'h0041);
        check("R9 status read cleared irq", irq, 0);
        bus_write(3'd7, 16'h00E7);
        bus_read(3'd7, v); check("R9 err cleared by accepted command", v, 16'h00C0);
        pulse(1);
        bus_read(3'd7, v);
    endtask

    task automatic t_stray();
        logic [15:0] v;
        pulse(1);
        pulse(0);
        check("R10 stray pulses no irq", irq, 0);
        bus_read(3'd7, v); check("R10 stray pulses status", v, 16'h0040);
        bus_write(3'd7, 16'h00CA);
        pulse(1);
        check("R10 flush_done ignored in DMA", dma_req, 1);
        check("R10 no irq from flush_done", irq, 0);
        pulse(0);
        bus_read(3'd7, v);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_identify();
        t_flush();
        t_dma(8'hC8, 1'b1);
        t_dma(8'hCA, 1'b0);
        t_busy_ignore();
        t_unknown();
        t_stray();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule